// File: doc/BRIEF.md
# Dual-Mode Binary/Decimal Digit Adder

This block adds two 4-bit operands and a carry-in. It has two modes. With the mode input low, it is a plain 4-bit binary adder with a carry-out. With the mode input high, each operand is taken as one decimal digit, 0 through 9. The output is then a decimal digit, and the carry-out is a decimal carry.

Both modes share one ripple datapath, built from identical one-bit full-adder cells. A second stage follows the ripple adder. It examines the raw 5-bit result and, only in decimal mode, adds six when that result is above nine. The output of that add is held to four bits.

The block is purely combinational. Several instances can be chained into a multi-digit adder by joining the carry-out of each digit to the carry-in of the next.

Top module: `bcd_digit_adder`

## Requirements
- R1: With `mode_bcd` = 0, `{carry_out, sum_out}` equals `op_a + op_b + carry_in` as an unsigned 5-bit value, for all 512 operand and carry combinations.
- R2: With `mode_bcd` = 1 and both operands in 0..9, `sum_out` equals `(op_a + op_b + carry_in) mod 10`.
- R3: With `mode_bcd` = 1 and both operands in 0..9, `carry_out` is 1 exactly when `op_a + op_b + carry_in` is greater than 9.
- R4: The largest decimal case, 9 + 9 + carry 1, gives `sum_out` = 4'b1001 with `carry_out` = 1.
- R5: The add-six correction keeps four bits. For example, 5 + 5 in decimal mode gives `sum_out` = 4'b0000 with `carry_out` = 1, and 8 + 8 gives 4'b0110 with `carry_out` = 1.
- R6: Binary mode applies no correction. For example, 5 + 5 with `mode_bcd` = 0 gives 4'b1010 with `carry_out` = 0.
- R7: Chaining two instances, with the low digit's `carry_out` driving the high digit's `carry_in`, adds two-digit decimal numbers. For example, 99 + 99 + 1 gives a carry of 1 and the digits 9 and 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | First operand (binary value, or a decimal digit in decimal mode) |
| op_b | input | 4 | Second operand |
| carry_in | input | 1 | Carry into the lowest bit |
| mode_bcd | input | 1 | 0 = binary addition, 1 = decimal digit addition |
| sum_out | output | 4 | Sum, binary or decimal digit |
| carry_out | output | 1 | Binary carry, or decimal carry in decimal mode |

## Verification
Binary mode is swept over every operand pair with both carry-in values. This shows the ripple chain is correct, and that no correction leaks in when the mode bit is low: the raw values 10 to 15 must come out unchanged.

Decimal mode is swept over all 100 valid digit pairs with both carry-in values. This separates results below ten, which pass through untouched, from results of ten to fifteen, where the six-add overflows out of bit 3 and that carry must be dropped. It also covers results of sixteen to nineteen, where the raw carry alone triggers the correction.

A two-instance chain is run on selected two-digit sums. This shows that the decimal carry moves correctly from one digit into the next, including when the lower digit produces a carry and the carry-in is also set.

// File: rtl/bcd_digit_adder_pkg.sv
// Shared constants and types for the dual-mode digit adder.
// Assumes one decimal digit fits in DIGIT_W bits (DIGIT_W >= 4).
package bcd_digit_adder_pkg;
    localparam int DIGIT_W = 4;
    localparam int RADIX   = 10;
    localparam int SPAN    = 1 << DIGIT_W;
    localparam logic [DIGIT_W-1:0] FIX_ADD = DIGIT_W'(SPAN - RADIX);
    typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/bcd_digit_adder_slice.sv
// One-bit full adder cell, used for every position of the ripple chain.
// Assumes nothing beyond single-bit inputs.
module bcd_digit_adder_slice (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    // Sum and carry of three bits.
    always_comb begin
        s_o = a_i ^ b_i ^ c_i;
        c_o = (a_i & b_i) | (c_i & (a_i ^ b_i));
    end
endmodule

// File: rtl/bcd_digit_adder_ripple.sv
// W-bit ripple adder built by repeating the full-adder slice.
// Assumes W >= 1; carry ripples from bit 0 upward.
module bcd_digit_adder_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] chain;

    // Seed the carry chain and expose its top.
    always_comb begin
        chain[0] = cin_i;
        cout_o   = chain[W];
    end

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            bcd_digit_adder_slice u_cell (
                .a_i (x_i[i]),
                .b_i (y_i[i]),
                .c_i (chain[i]),
                .s_o (sum_o[i]),
                .c_o (chain[i+1])
            );
        end
    endgenerate
endmodule

// File: rtl/bcd_digit_adder_fix.sv
// Decimal correction stage: spots raw results above nine and, in decimal
// mode only, adds the radix gap (six) modulo 2**W. The carry out of the top
// bit of that add is never formed. Assumes the raw input is a W+1-bit sum.
module bcd_digit_adder_fix
    import bcd_digit_adder_pkg::*;
(
    input  digit_t raw_sum_i,
    input  logic   raw_cy_i,
    input  logic   dec_en_i,
    output digit_t sum_o,
    output logic   cy_o
);
    logic   over_nine;
    digit_t addend;
    logic [DIGIT_W-1:0] cc;

    // Detect raw values of ten or more (carry, or 1x1x / 11xx pattern).
    always_comb begin
        over_nine = raw_cy_i
                  | (raw_sum_i[DIGIT_W-1] & raw_sum_i[DIGIT_W-2])
                  | (raw_sum_i[DIGIT_W-1] & raw_sum_i[DIGIT_W-3]);
        addend    = (dec_en_i && over_nine) ? FIX_ADD : '0;
        cy_o      = dec_en_i ? over_nine : raw_cy_i;
        cc[0]     = 1'b0;
    end

    genvar k;
    generate
        for (k = 0; k < DIGIT_W; k++) begin : g_fix
            // Sum bit of the correction add at position k.
            always_comb sum_o[k] = raw_sum_i[k] ^ addend[k] ^ cc[k];
            if (k < DIGIT_W - 1) begin : g_carry
                // Carry into the next position; none leaves the top bit.
                always_comb cc[k+1] = (raw_sum_i[k] & addend[k])
                                    | (cc[k] & (raw_sum_i[k] ^ addend[k]));
            end
        end
    endgenerate
endmodule

// File: rtl/bcd_digit_adder.sv
// Top: one ripple adder shared by binary and decimal modes, followed by the
// mode-gated decimal correction. Purely combinational; decimal results are
// meaningful only for operand digits 0..9.
module bcd_digit_adder
    import bcd_digit_adder_pkg::*;
(
    input  logic [3:0] op_a,
    input  logic [3:0] op_b,
    input  logic       carry_in,
    input  logic       mode_bcd,
    output logic [3:0] sum_out,
    output logic       carry_out
);
    digit_t raw_sum;
    logic   raw_cy;

    bcd_digit_adder_ripple #(.W(DIGIT_W)) u_add (
        .x_i    (op_a),
        .y_i    (op_b),
        .cin_i  (carry_in),
        .sum_o  (raw_sum),
        .cout_o (raw_cy)
    );

    bcd_digit_adder_fix u_fix (
        .raw_sum_i (raw_sum),
        .raw_cy_i  (raw_cy),
        .dec_en_i  (mode_bcd),
        .sum_o     (sum_out),
        .cy_o      (carry_out)
    );
endmodule

// File: rtl/bcd_digit_adder_chk.sv
// Checker for the digit adder; compares ports against arithmetic.
// Assumes inputs are settled whenever the combinational block evaluates.
module bcd_digit_adder_chk (
    input logic [3:0] op_a,
    input logic [3:0] op_b,
    input logic       carry_in,
    input logic       mode_bcd,
    input logic [3:0] sum_out,
    input logic       carry_out
);
    int  tot;
    logic digits_ok;

    // Evaluate all port relations whenever anything changes.
    always_comb begin
        tot       = int'(op_a) + int'(op_b) + int'(carry_in);
        digits_ok = (op_a <= 4'd9) && (op_b <= 4'd9);
        if (!mode_bcd) begin
            a_r1_binary_sum: assert ({carry_out, sum_out} == 5'(tot))
                else $error("binary sum mismatch");
        end
        if (mode_bcd && digits_ok) begin
            a_r2_decimal_digit: assert (int'(sum_out) == tot % 10)
                else $error("decimal digit mismatch");
            a_r3_decimal_carry: assert (carry_out == (tot > 9))
                else $error("decimal carry mismatch");
            a_r5_digit_range: assert (sum_out <= 4'd9)
                else $error("decimal digit out of range");
        end
    end
endmodule

bind bcd_digit_adder bcd_digit_adder_chk chk_i (.*);

// File: tb/bcd_digit_adder_test.sv
module bcd_digit_adder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] a, b, a_hi, b_hi;
    logic cin, mode;
    logic [3:0] s, s_hi;
    logic co, co_hi;
    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    bcd_digit_adder uut (
        .op_a(a), .op_b(b), .carry_in(cin), .mode_bcd(mode),
        .sum_out(s), .carry_out(co));

    bcd_digit_adder uut_hi (
        .op_a(a_hi), .op_b(b_hi), .carry_in(co), .mode_bcd(1'b1),
        .sum_out(s_hi), .carry_out(co_hi));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input int va, input int vb, input int vc, input bit m);
        @(posedge clk);
        a = 4'(va); b = 4'(vb); cin = vc[0]; mode = m;
        @(negedge clk);
    endtask

    task automatic chain(input int x, input int y, input int c);
        int e;
        @(posedge clk);
        a = 4'(x % 10); a_hi = 4'(x / 10);
        b = 4'(y % 10); b_hi = 4'(y / 10);
        cin = c[0]; mode = 1'b1;
        @(negedge clk);
        e = x + y + c;
        // R7: two-digit decimal chain
        check(int'(co_hi) * 100 + int'(s_hi) * 10 + int'(s) == e, "R7",
              int'(co_hi) * 100 + int'(s_hi) * 10 + int'(s), e);
    endtask

    initial begin
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        a = '0; b = '0; a_hi = '0; b_hi = '0; cin = 1'b0; mode = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: all-zero inputs give zero result
        check({co, s} == 5'd0, "R1", int'({co, s}), 0);

        // R1: exhaustive binary sweep
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                for (int k = 0; k < 2; k++) begin
                    apply(i, j, k, 1'b0);
                    check(int'({co, s}) == i + j + k, "R1", int'({co, s}), i + j + k);
                end

        // R2 and R3: exhaustive valid decimal sweep
        for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++)
                for (int k = 0; k < 2; k++) begin
                    apply(i, j, k, 1'b1);
                    check(int'(s) == (i + j + k) % 10, "R2", int'(s), (i + j + k) % 10);
                    check(int'(co) == int'((i + j + k) > 9), "R3", int'(co), int'((i + j + k) > 9));
                end

        // R4: largest decimal case
        apply(9, 9, 1, 1'b1);
        check(s == 4'b1001 && co, "R4", int'({co, s}), 5'b11001);
        // R5: correction overflow dropped
        apply(5, 5, 0, 1'b1);
        check(s == 4'b0000 && co, "R5", int'({co, s}), 5'b10000);
        apply(8, 8, 0, 1'b1);
        check(s == 4'b0110 && co, "R5", int'({co, s}), 5'b10110);
        // R6: no correction in binary mode
        apply(5, 5, 0, 1'b0);
        check(s == 4'b1010 && !co, "R6", int'({co, s}), 5'b01010);
        apply(7, 8, 0, 1'b0);
        check(s == 4'b1111 && !co, "R6", int'({co, s}), 5'b01111);

        // R7: two-digit chains
        chain(47, 38, 0);
        chain(99, 99, 1);
        chain(50, 50, 0);
        chain(19, 0, 1);
        chain(0, 0, 0);
        chain(65, 34, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule